// File: doc/BRIEF.md
# Limb-Serial Multiple-Precision Multiplier

This block multiplies two unsigned integers of arbitrary length, each held as a run of 64-bit limbs in an external register file. It works through the schoolbook method one column at a time. Within a column it fetches every operand limb pair whose indices add up to that column, one pair per cycle, and forms the 128-bit product of each pair. The lower half of each product is summed into the accumulator of the current column. The upper half is summed into the accumulator of the following column.

Two accumulators serve these two roles and swap them at the end of each column. Each accumulator has headroom bits above the limb width, so a long column cannot lose a carry. When a column is complete, its sum goes to a carry-propagate stage. That stage adds the carry left by the previous column, emits one finished limb and keeps the excess as the next carry. Result limbs therefore leave the block least significant first, without a full-width result register.

A host pulses a start strobe together with the two operand sizes. It serves the two read ports, which return data one cycle after an address is presented. It then collects the valid-qualified limb stream until the done pulse. Signs are handled outside this block.

Top module: `mp_limb_multiplier`

## Requirements
- R1: Out of reset, and whenever the block is idle, `busyOut`, `rdEn`, `limbValid` and `doneOut` are all low.
- R2: For operand sizes na ≥ 1 and nb ≥ 1, the limb stream is the product A·B, limb k carrying bits 64k+63..64k, in strictly increasing k.
- R3: A run with na, nb ≥ 1 emits exactly na+nb limbs. `doneOut` is then high for one cycle, in the cycle right after the last valid limb.
- R4: If either size is zero, the run emits exactly one limb of value 0, and `doneOut` follows in the next cycle.
- R5: Read port timing: `rdDataA`/`rdDataB` must hold the addressed limb in the cycle after `rdEn`. While `rdEn` is high, `rdAddrA` < na and `rdAddrB` < nb.
- R6: A start pulse while `busyOut` is high is ignored: the running product completes unchanged, and no second run follows.
- R7: `busyOut` rises in the cycle after an accepted start. It stays high through the done pulse and falls in the cycle after it.
- R8: The carry left after the top limb is always zero, so the result is exact even for all-ones operands of maximum size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe, taken only when idle |
| sizeA | input | SIZE_W | Limb count of operand A (0..MAX_LIMBS) |
| sizeB | input | SIZE_W | Limb count of operand B (0..MAX_LIMBS) |
| busyOut | output | 1 | Run in progress |
| rdEn | output | 1 | Read request on both operand ports |
| rdAddrA | output | IDX_W | Limb index into operand A |
| rdAddrB | output | IDX_W | Limb index into operand B |
| rdDataA | input | LIMB_W | Operand A limb, one cycle after the request |
| rdDataB | input | LIMB_W | Operand B limb, one cycle after the request |
| limbValid | output | 1 | Result limb valid |
| limbData | output | LIMB_W | Result limb, least significant first |
| doneOut | output | 1 | One-cycle pulse after the last result limb |

## Verification
The assertions assume three things about the host. Operand sizes never exceed MAX_LIMBS. The read ports respond with fixed one-cycle latency. The operand storage is not rewritten during a run. The bench keeps to these by modelling the storage as a registered array that it fills only while `busyOut` is low, and by sweeping sizes only over 0..MAX_LIMBS. Storage slots beyond each operand's size hold a marker value, so a fetch outside the operand would corrupt the product. The bench also sends start pulses with other sizes during a busy run, to show that the host may violate the start protocol without harm.

// File: rtl/mp_mul_pkg.sv
package mp_mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN
  } ctrlState_t;

  // Strobes from the sequencer to the datapath, one token per cycle
  typedef struct packed {
    logic clearAcc;   // new run: zero accumulators and carry
    logic tokValid;   // a token enters the pipeline this cycle
    logic tokZero;    // token carries no product (tail / zero-size flush)
    logic tokColEnd;  // token is the last contribution to its column
    logic tokLast;    // token closes the final result limb
  } mulStrobes_t;

endpackage

// File: rtl/mp_mul_ctrl.sv
module mp_mul_ctrl
  import mp_mul_pkg::*;
#(
  parameter int MAX_LIMBS = 4,
  parameter int SIZE_W    = 3,
  parameter int IDX_W     = 2,
  parameter int COL_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [SIZE_W-1:0] sizeA,
  input  logic [SIZE_W-1:0] sizeB,
  input  logic              finishIn,
  output logic              busyOut,
  output logic              rdEn,
  output logic [IDX_W-1:0]  rdAddrA,
  output logic [IDX_W-1:0]  rdAddrB,
  output mulStrobes_t       strb
);

  ctrlState_t        state;
  logic [SIZE_W-1:0] naR, nbR;
  logic [COL_W-1:0]  colR;
  logic [IDX_W-1:0]  iR;
  logic              tailR;

  logic              startAcc;
  logic [COL_W-1:0]  naC, nbC, iC, lastCol, iEndC, colNext, iStartNext;
  logic              colEnd;

  always_comb begin
    startAcc   = startIn && (state == ST_IDLE);
    naC        = COL_W'(naR);
    nbC        = COL_W'(nbR);
    iC         = COL_W'(iR);
    lastCol    = naC + nbC - COL_W'(2);
    iEndC      = (colR < naC) ? colR : (naC - COL_W'(1));
    colNext    = colR + COL_W'(1);
    iStartNext = (colNext >= nbC) ? (colNext - nbC + COL_W'(1)) : '0;
    colEnd     = (iC == iEndC);

    busyOut    = (state != ST_IDLE);
    rdEn       = (state == ST_ISSUE) && !tailR;
    rdAddrA    = iR;
    rdAddrB    = IDX_W'(colR - iC);

    strb.clearAcc  = startAcc;
    strb.tokValid  = (state == ST_ISSUE);
    strb.tokZero   = tailR;
    strb.tokColEnd = tailR || colEnd;
    strb.tokLast   = tailR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      naR   <= '0;
      nbR   <= '0;
      colR  <= '0;
      iR    <= '0;
      tailR <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startAcc) begin
            naR   <= sizeA;
            nbR   <= sizeB;
            colR  <= '0;
            iR    <= '0;
            tailR <= (sizeA == '0) || (sizeB == '0);
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (tailR) begin
            state <= ST_DRAIN;
          end else if (colEnd) begin
            if (colR == lastCol) begin
              tailR <= 1'b1;
            end else begin
              colR <= colNext;
              iR   <= IDX_W'(iStartNext);
            end
          end else begin
            iR <= iR + IDX_W'(1);
          end
        end
        ST_DRAIN: begin
          if (finishIn) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mp_mul_datapath.sv
module mp_mul_datapath
  import mp_mul_pkg::*;
#(
  parameter int LIMB_W = 64,
  parameter int ACC_W  = 68
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobes_t       strb,
  input  logic [LIMB_W-1:0] rdDataA,
  input  logic [LIMB_W-1:0] rdDataB,
  output logic              limbValid,
  output logic [LIMB_W-1:0] limbData,
  output logic              doneOut,
  output logic [ACC_W-1:0]  carryOut
);

  localparam int PROD_W = 2 * LIMB_W;

  // Stage 1: tags wait for the read data
  logic s1V, s1Z, s1E, s1L;
  // Stage 2: registered 128-bit product
  logic              pV, pE, pL;
  logic [PROD_W-1:0] prodQ, mulRes;
  // Stage 3: column accumulation
  logic              sel;
  logic [ACC_W-1:0]  accView [2];
  logic [ACC_W-1:0]  loPart, hiPart;
  logic              colV, colL;
  logic [ACC_W-1:0]  colSum;
  // Stage 4: carry propagate
  logic [ACC_W:0]    partSum;
  logic [ACC_W-1:0]  carryQ;
  logic              lastO;

  always_comb begin
    mulRes  = {{LIMB_W{1'b0}}, rdDataA} * {{LIMB_W{1'b0}}, rdDataB};
    loPart  = ACC_W'(prodQ[LIMB_W-1:0]);
    hiPart  = ACC_W'(prodQ[PROD_W-1:LIMB_W]);
    partSum = {1'b0, colSum} + {1'b0, carryQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1V <= 1'b0; s1Z <= 1'b0; s1E <= 1'b0; s1L <= 1'b0;
      pV  <= 1'b0; pE  <= 1'b0; pL  <= 1'b0;
      prodQ <= '0;
    end else begin
      s1V <= strb.tokValid;
      s1Z <= strb.tokZero;
      s1E <= strb.tokColEnd;
      s1L <= strb.tokLast;
      pV  <= s1V;
      pE  <= s1E;
      pL  <= s1L;
      prodQ <= s1Z ? '0 : mulRes;
    end
  end

  // Two accumulator slots: slot 'sel' takes low halves for the current column,
  // the other slot gathers high halves for the next column.
  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic [ACC_W-1:0] accQ;
    always_ff @(posedge clk) begin
      if (!rstN || strb.clearAcc) begin
        accQ <= '0;
      end else if (pV) begin
        if (sel == 1'(g)) accQ <= pE ? '0 : (accQ + loPart);
        else              accQ <= accQ + hiPart;
      end
    end
    assign accView[g] = accQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAcc) begin
      sel    <= 1'b0;
      colV   <= 1'b0;
      colL   <= 1'b0;
      colSum <= '0;
    end else begin
      colV <= pV && pE;
      colL <= pV && pE && pL;
      if (pV && pE) begin
        colSum <= accView[sel] + loPart;
        sel    <= ~sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAcc) begin
      carryQ    <= '0;
      limbValid <= 1'b0;
      limbData  <= '0;
      lastO     <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      limbValid <= colV;
      lastO     <= colL;
      doneOut   <= limbValid && lastO;
      if (colV) begin
        limbData <= partSum[LIMB_W-1:0];
        carryQ   <= ACC_W'(partSum[ACC_W:LIMB_W]);
      end
    end
  end

  assign carryOut = carryQ;

endmodule

// File: rtl/mp_limb_multiplier.sv
module mp_limb_multiplier
  import mp_mul_pkg::*;
#(
  parameter  int LIMB_W    = 64,
  parameter  int MAX_LIMBS = 4,
  localparam int SIZE_W    = $clog2(MAX_LIMBS + 1),
  localparam int IDX_W     = $clog2(MAX_LIMBS),
  localparam int COL_W     = $clog2(2 * MAX_LIMBS + 1),
  localparam int ACC_W     = LIMB_W + $clog2(MAX_LIMBS) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [SIZE_W-1:0] sizeA,
  input  logic [SIZE_W-1:0] sizeB,
  output logic              busyOut,
  output logic              rdEn,
  output logic [IDX_W-1:0]  rdAddrA,
  output logic [IDX_W-1:0]  rdAddrB,
  input  logic [LIMB_W-1:0] rdDataA,
  input  logic [LIMB_W-1:0] rdDataB,
  output logic              limbValid,
  output logic [LIMB_W-1:0] limbData,
  output logic              doneOut
);

  mulStrobes_t      strb;
  logic [ACC_W-1:0] carryTap;

  mp_mul_ctrl #(
    .MAX_LIMBS(MAX_LIMBS), .SIZE_W(SIZE_W), .IDX_W(IDX_W), .COL_W(COL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .sizeA(sizeA), .sizeB(sizeB),
    .finishIn(doneOut), .busyOut(busyOut), .rdEn(rdEn),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .strb(strb)
  );

  mp_mul_datapath #(
    .LIMB_W(LIMB_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .limbValid(limbValid), .limbData(limbData), .doneOut(doneOut),
    .carryOut(carryTap)
  );

endmodule

// File: rtl/mp_mul_checker.sv
module mp_mul_checker #(
  parameter int SIZE_W = 3,
  parameter int IDX_W  = 2,
  parameter int COL_W  = 4,
  parameter int ACC_W  = 68
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic [SIZE_W-1:0] sizeA,
  input logic [SIZE_W-1:0] sizeB,
  input logic              busyOut,
  input logic              rdEn,
  input logic [IDX_W-1:0]  rdAddrA,
  input logic [IDX_W-1:0]  rdAddrB,
  input logic              limbValid,
  input logic              doneOut,
  input logic [ACC_W-1:0]  carryQ
);

  logic [SIZE_W-1:0] latA, latB;
  logic [COL_W-1:0]  limbCnt, expCnt;
  logic              accepted;

  assign accepted = startIn && !busyOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latA <= '0; latB <= '0; limbCnt <= '0; expCnt <= '0;
    end else if (accepted) begin
      latA    <= sizeA;
      latB    <= sizeB;
      limbCnt <= '0;
      expCnt  <= ((sizeA == '0) || (sizeB == '0)) ? COL_W'(1)
                                                   : (COL_W'(sizeA) + COL_W'(sizeB));
    end else if (limbValid) begin
      limbCnt <= limbCnt + COL_W'(1);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> (!rdEn && !limbValid && !doneOut));

  assert_limb_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (limbCnt == expCnt));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  assert_read_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> ((SIZE_W'(rdAddrA) < latA) && (SIZE_W'(rdAddrB) < latB)));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn && !doneOut) |=> busyOut);

  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> busyOut);

  assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !busyOut);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (carryQ == '0));

endmodule

bind mp_limb_multiplier mp_mul_checker #(
  .SIZE_W(SIZE_W), .IDX_W(IDX_W), .COL_W(COL_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .sizeA(sizeA), .sizeB(sizeB),
  .busyOut(busyOut), .rdEn(rdEn), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
  .limbValid(limbValid), .doneOut(doneOut), .carryQ(carryTap)
);

// File: tb/sim_mp_limb_multiplier.sv
`timescale 1ns/1ps
module sim_mp_limb_multiplier;

  localparam int LW     = 64;
  localparam int MAXL   = 4;
  localparam int SIZE_W = $clog2(MAXL + 1);
  localparam int IDX_W  = $clog2(MAXL);
  localparam logic [LW-1:0] MARK = 64'hDEAD_BEEF_0BAD_F00D;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startIn = 1'b0;
  logic [SIZE_W-1:0] sizeA = '0, sizeB = '0;
  logic              busyOut, rdEn, limbValid, doneOut;
  logic [IDX_W-1:0]  rdAddrA, rdAddrB;
  logic [LW-1:0]     rdDataA = '0, rdDataB = '0, limbData;

  logic [LW-1:0]        memA [MAXL];
  logic [LW-1:0]        memB [MAXL];
  logic [MAXL*LW-1:0]   bigA, bigB;
  logic [2*MAXL*LW-1:0] refProd;
  logic [LW-1:0]        got [2*MAXL+2];

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mp_limb_multiplier #(.LIMB_W(LW), .MAX_LIMBS(MAXL)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .sizeA(sizeA), .sizeB(sizeB),
    .busyOut(busyOut), .rdEn(rdEn), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .limbValid(limbValid),
    .limbData(limbData), .doneOut(doneOut)
  );

  // Registered operand storage: one-cycle read latency (R5)
  always @(posedge clk) begin
    if (rdEn) begin
      rdDataA <= memA[rdAddrA];
      rdDataB <= memB[rdAddrB];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] genLimb(input int pat, input int seed);
    logic [LW-1:0] v;
    v = 64'h9E37_79B9_7F4A_7C15 * LW'(seed + 7);
    v = v ^ (v >> 29) ^ (v << 17);
    case (pat)
      0:       return v;
      1:       return '1;
      default: return LW'(1) << (seed % LW);
    endcase
  endfunction

  task automatic fill(input int pat, input int a, input int b);
    bigA = '0;
    bigB = '0;
    for (int k = 0; k < MAXL; k++) begin
      logic [LW-1:0] va, vb;
      va = genLimb(pat, 2 * k + 11 * a);
      vb = genLimb(pat, 2 * k + 1 + 5 * b);
      memA[k] = (k < a) ? va : MARK;
      memB[k] = (k < b) ? vb : ~MARK;
      if (k < a) bigA[k*LW +: LW] = va;
      if (k < b) bigB[k*LW +: LW] = vb;
    end
    refProd = {{(MAXL*LW){1'b0}}, bigA} * {{(MAXL*LW){1'b0}}, bigB};
  endtask

  task automatic runCase(input int pat, input int a, input int b, input bit poke);
    int  n = 0;
    int  cyc = 0;
    bit  prevValid = 0;
    bit  seenDone = 0;
    bit  rangeOk = 1;
    int  expN;
    string req;
    @(negedge clk);
    fill(pat, a, b);
    sizeA = SIZE_W'(a);
    sizeB = SIZE_W'(b);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(busyOut == 1'b1, "R7", "busy after start", LW'(busyOut), LW'(1));
    while (!seenDone && cyc < 500) begin
      if (rdEn && (int'(rdAddrA) >= a || int'(rdAddrB) >= b)) rangeOk = 0;
      if (doneOut) begin
        seenDone = 1;
        check(prevValid && !limbValid, "R3", "done follows last limb",
              LW'({prevValid, limbValid}), LW'(2));
      end else begin
        if (limbValid && n < 2 * MAXL + 2) got[n] = limbData;
        if (limbValid) n++;
        prevValid = limbValid;
        if (poke && cyc == 2) begin
          sizeA = SIZE_W'(MAXL - a);
          sizeB = SIZE_W'(1);
          startIn = 1'b1;
        end
        if (poke && cyc == 3) startIn = 1'b0;
        @(negedge clk);
        cyc++;
      end
    end
    startIn = 1'b0;
    if (!seenDone) check(0, "R3", "watchdog: no done", LW'(cyc), LW'(0));
    check(rangeOk, "R5", "read addresses within operand sizes", LW'(rangeOk), LW'(1));
    expN = (a == 0 || b == 0) ? 1 : a + b;
    req  = (a == 0 || b == 0) ? "R4" : "R3";
    check(n == expN, req, "limb count", LW'(n), LW'(expN));
    for (int k = 0; k < expN && k < n; k++) begin
      logic [LW-1:0] e;
      e = (a == 0 || b == 0) ? '0 : refProd[k*LW +: LW];
      if (a == 0 || b == 0)      req = "R4";
      else if (poke)             req = "R6";
      else if (pat == 1)         req = "R8";
      else                       req = "R2";
      check(got[k] == e, req, $sformatf("limb %0d (a=%0d b=%0d p=%0d)", k, a, b, pat),
            got[k], e);
    end
    @(negedge clk);
    check(!busyOut && !doneOut, "R7", "idle after done", LW'({busyOut, doneOut}), LW'(0));
    if (poke) begin
      repeat (3) @(negedge clk);
      check(!busyOut && !limbValid, "R6", "no run from ignored start",
            LW'({busyOut, limbValid}), LW'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busyOut && !rdEn && !limbValid && !doneOut, "R1", "outputs in reset",
          LW'({busyOut, rdEn, limbValid, doneOut}), LW'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(!busyOut && !rdEn && !limbValid && !doneOut, "R1", "idle after reset",
          LW'({busyOut, rdEn, limbValid, doneOut}), LW'(0));
    for (int p = 0; p < 3; p++)
      for (int a = 0; a <= MAXL; a++)
        for (int b = 0; b <= MAXL; b++)
          runCase(p, a, b, 1'b0);
    runCase(0, 3, 2, 1'b1);
    runCase(1, MAXL, MAXL, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule